// File: doc/BRIEF.md
# Read Latency Output Pipeline

This block is the data output stage of a synchronous DRAM model. The core supplies read words one per clock, each with a valid strobe. The block holds every accepted word for a programmable read latency of two or three clocks and then places it on a 32-bit data bus. A per-lane enable says whether each byte lane is driven or floating (high impedance). While a lane floats, its data bits are shown as zero.

A four-bit byte mask turns individual lanes off after a fixed two-clock delay, whatever the read latency is. Two events shorten a read burst, and each has its own turn-off delay. A precharge event stops words from the edge of the event onward. A burst-stop event also removes the word taken one edge earlier. After either event, further words are dropped until one arrives that is flagged as the first word of a new burst. A new burst that follows an old one, either back to back or as an interruption, comes out right behind the old burst's queued words with no gap.

Top module: `rd_latency_pipe`

## Requirements
- R1: The latency setting is loaded from the 3-bit field `cfg_lat` when `cfg_load` is high at a rising edge. Only the values 3'b010 (two clocks) and 3'b011 (three clocks) are taken. Every other value is ignored and the previous setting is kept. Reset selects three clocks. A new setting applies to words taken from the next edge onward.
- R2: A word is taken at rising edge n when `rd_vld` is high, no event is present, and either the gate is open or `rd_first` is high. With latency L, that word is on `dq_out` with all four `dq_oe` bits high during the clock period that ends at edge n+L. In every period where no word is due, and while reset is held, `dq_oe` is 4'b0000 and `dq_out` is zero.
- R3: Words taken on consecutive edges leave on consecutive periods, in the order they were taken. This also holds when a new burst (`rd_first` high) directly follows or interrupts an earlier one.
- R4: If `byte_mask[k]` is high at edge m, lane k (bits 8k+7..8k) floats in the period that ends at edge m+2, for either latency. `dq_oe[k]` is low and the lane reads zero. The other lanes are not affected.
- R5: A precharge event (`pre_evt`) at edge t discards any word offered at t or later. Words taken before t still leave, so the bus floats from the period ending at t+L.
- R6: A burst-stop event (`stop_evt`) at edge t discards the word offered at t and also the word taken at t-1. The bus floats from the period ending at t+L-1.
- R7: After a precharge or burst-stop event, words offered with `rd_first` low are discarded. The first word that arrives with `rd_first` high is taken and reopens the gate.
- R8: Changing the latency never moves words that are already queued. They leave at the latency they were taken with.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all activity on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_load | input | 1 | Loads the latency field |
| cfg_lat | input | 3 | Latency field (2 or 3 are legal) |
| rd_vld | input | 1 | Read word valid |
| rd_first | input | 1 | First word of a new burst |
| rd_data | input | 32 | Read word from the core |
| byte_mask | input | 4 | Per-lane output mask |
| pre_evt | input | 1 | Precharge event |
| stop_evt | input | 1 | Burst-stop event |
| dq_out | output | 32 | Data bus value (zero in floating lanes) |
| dq_oe | output | 4 | Per-lane drive enable |

## Verification
The hardest case to reach is a burst-stop event that removes a word which is already inside the delay line, rather than one that is still at the input. For that word to be affected, the stop must arrive exactly one edge after the word was taken, while older words of the same burst are still draining. The bench reaches this by holding a continuous burst and raising the stop in the middle of it, at both latencies. It then offers unflagged words so that the closed gate can be seen, and ends with a flagged word that must follow right behind the survivors. A second hard case is a latency change while a word is in flight: one word is taken at three clocks, the field is reloaded to two clocks, and a second word is sent, so both must leave at their own delays.

// File: rtl/rlp_pkg.sv
package rlp_pkg;
   // Check whether a latency code falls inside the supported range.
   function automatic logic lat_legal(input int code, input int lo, input int hi);
      return (code >= lo) && (code <= hi);
   endfunction
endpackage

// File: rtl/rlp_lat_cfg.sv
module rlp_lat_cfg #(
   parameter int LAT_W   = 3,
   parameter int LAT_MIN = 2,
   parameter int LAT_MAX = 3,
   parameter int LAT_RST = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [LAT_W-1:0] field,
   output logic [LAT_W-1:0] lat
);
   if (LAT_MIN < 1 || LAT_MAX < LAT_MIN || LAT_RST < LAT_MIN || LAT_RST > LAT_MAX
       || LAT_MAX >= (1 << LAT_W)) begin : g_bad_cfg
      $error("rlp_lat_cfg: latency range does not fit");
   end

   logic take;
   assign take = load && rlp_pkg::lat_legal(int'(field), LAT_MIN, LAT_MAX);

   always_ff @(posedge clk) begin
      if (!rst_n)    lat <= LAT_W'(LAT_RST);
      else if (take) lat <= field;
   end

   // R1
   lat_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rlp_pkg::lat_legal(int'(lat), LAT_MIN, LAT_MAX));
   // R1
   bad_load_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (load && !rlp_pkg::lat_legal(int'(field), LAT_MIN, LAT_MAX)) |=> $stable(lat));
endmodule

// File: rtl/rlp_burst_gate.sv
module rlp_burst_gate (
   input  logic clk,
   input  logic rst_n,
   input  logic rd_vld,
   input  logic rd_first,
   input  logic pre_evt,
   input  logic stop_evt,
   output logic accept
);
   logic blk;

   assign accept = rd_vld && !pre_evt && !stop_evt && (!blk || rd_first);

   always_ff @(posedge clk) begin
      if (!rst_n)                  blk <= 1'b0;
      else if (pre_evt || stop_evt) blk <= 1'b1;
      else if (accept && rd_first)  blk <= 1'b0;
   end
endmodule

// File: rtl/rlp_data_pipe.sv
module rlp_data_pipe #(
   parameter int DATA_W = 32,
   parameter int LAT_W  = 3,
   parameter int DEPTH  = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ins,
   input  logic [DATA_W-1:0] ins_data,
   input  logic [LAT_W-1:0]  lat,
   input  logic              stop,
   output logic              out_vld,
   output logic [DATA_W-1:0] out_data
);
   localparam int IDX_W = $clog2(DEPTH + 1);

   logic [DEPTH:1]    vld, live, nvld;
   logic [DATA_W-1:0] dat  [1:DEPTH];
   logic [DATA_W-1:0] ndat [1:DEPTH];
   logic [IDX_W-1:0]  ins_idx, prev_idx;
   logic              prev_ins, ins_ok;

   // A new word enters at the stage whose distance to the output equals its latency.
   assign ins_idx = IDX_W'(DEPTH + 1 - int'(lat));

   always_comb begin
      live = vld;
      if (stop && prev_ins) live[prev_idx] = 1'b0;
      nvld   = '0;
      ndat   = dat;
      ins_ok = 1'b0;
      if (ins && int'(ins_idx) == 1) begin
         nvld[1] = 1'b1;
         ndat[1] = ins_data;
         ins_ok  = 1'b1;
      end
      for (int i = 2; i <= DEPTH; i++) begin
         if (live[i-1]) begin
            nvld[i] = 1'b1;
            ndat[i] = dat[i-1];
         end else if (ins && int'(ins_idx) == i) begin
            nvld[i] = 1'b1;
            ndat[i] = ins_data;
            ins_ok  = 1'b1;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         vld      <= '0;
         prev_ins <= 1'b0;
         prev_idx <= '0;
      end else begin
         vld      <= nvld;
         prev_ins <= ins_ok;
         prev_idx <= ins_idx;
      end
   end

   always_ff @(posedge clk) begin
      for (int i = 1; i <= DEPTH; i++) dat[i] <= ndat[i];
   end

   assign out_vld  = vld[DEPTH];
   assign out_data = dat[DEPTH];
endmodule

// File: rtl/rlp_mask_delay.sv
module rlp_mask_delay #(
   parameter int LANES    = 4,
   parameter int MASK_LAT = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [LANES-1:0] mask_in,
   output logic [LANES-1:0] mask_out
);
   if (MASK_LAT == 0) begin : g_direct
      assign mask_out = mask_in;
   end else begin : g_shift
      logic [LANES-1:0] sh [MASK_LAT];
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            for (int k = 0; k < MASK_LAT; k++) sh[k] <= '0;
         end else begin
            sh[0] <= mask_in;
            for (int k = 1; k < MASK_LAT; k++) sh[k] <= sh[k-1];
         end
      end
      assign mask_out = sh[MASK_LAT-1];
   end
endmodule

// File: rtl/rd_latency_pipe.sv
module rd_latency_pipe #(
   parameter int DATA_W   = 32,
   parameter int LANE_W   = 8,
   parameter int LAT_W    = 3,
   parameter int LAT_MIN  = 2,
   parameter int LAT_MAX  = 3,
   parameter int LAT_RST  = 3,
   parameter int MASK_LAT = 2,
   localparam int LANES   = DATA_W / LANE_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cfg_load,
   input  logic [LAT_W-1:0]  cfg_lat,
   input  logic              rd_vld,
   input  logic              rd_first,
   input  logic [DATA_W-1:0] rd_data,
   input  logic [LANES-1:0]  byte_mask,
   input  logic              pre_evt,
   input  logic              stop_evt,
   output logic [DATA_W-1:0] dq_out,
   output logic [LANES-1:0]  dq_oe
);
   if (DATA_W % LANE_W != 0 || LAT_MIN < 2) begin : g_bad_top
      $error("rd_latency_pipe: lane width or minimum latency unsupported");
   end

   logic [LAT_W-1:0]  lat;
   logic              accept, out_vld;
   logic [DATA_W-1:0] out_data;
   logic [LANES-1:0]  mask_d;

   rlp_lat_cfg #(.LAT_W(LAT_W), .LAT_MIN(LAT_MIN), .LAT_MAX(LAT_MAX), .LAT_RST(LAT_RST)) u_cfg (
      .clk(clk), .rst_n(rst_n), .load(cfg_load), .field(cfg_lat), .lat(lat));

   rlp_burst_gate u_gate (
      .clk(clk), .rst_n(rst_n), .rd_vld(rd_vld), .rd_first(rd_first),
      .pre_evt(pre_evt), .stop_evt(stop_evt), .accept(accept));

   rlp_data_pipe #(.DATA_W(DATA_W), .LAT_W(LAT_W), .DEPTH(LAT_MAX)) u_pipe (
      .clk(clk), .rst_n(rst_n), .ins(accept), .ins_data(rd_data), .lat(lat),
      .stop(stop_evt), .out_vld(out_vld), .out_data(out_data));

   rlp_mask_delay #(.LANES(LANES), .MASK_LAT(MASK_LAT)) u_mask (
      .clk(clk), .rst_n(rst_n), .mask_in(byte_mask), .mask_out(mask_d));

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      assign dq_oe[g] = out_vld && !mask_d[g];
      assign dq_out[g*LANE_W +: LANE_W] = dq_oe[g] ? out_data[g*LANE_W +: LANE_W] : '0;
   end

   // Checker state: edges since reset and since the last latency load (saturating).
   logic [1:0] since_rst, quiet;
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         since_rst <= '0;
         quiet     <= 2'd3;
      end else begin
         if (since_rst != 2'd3) since_rst <= since_rst + 2'd1;
         if (cfg_load)          quiet <= '0;
         else if (quiet != 2'd3) quiet <= quiet + 2'd1;
      end
   end

   // R6
   stop_gap_l2_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && quiet == 2'd3 && lat == LAT_W'(2)) |=> !out_vld);
   // R6
   stop_gap_l3_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_evt && quiet == 2'd3 && lat == LAT_W'(3)) |=> ##1 !out_vld);
   // R4
   mask_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (since_rst >= 2'd2) |-> ((dq_oe & $past(byte_mask, 2)) == '0));
endmodule

// File: tb/sim_rd_latency_pipe.sv
module sim_rd_latency_pipe;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        cfg_load = 1'b0;
   logic [2:0]  cfg_lat = 3'd0;
   logic        rd_vld = 1'b0, rd_first = 1'b0, pre_evt = 1'b0, stop_evt = 1'b0;
   logic [31:0] rd_data = '0;
   logic [3:0]  byte_mask = '0;
   logic [31:0] dq_out;
   logic [3:0]  dq_oe;

   always #4 clk = ~clk;

   rd_latency_pipe u0 (
      .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_lat(cfg_lat),
      .rd_vld(rd_vld), .rd_first(rd_first), .rd_data(rd_data), .byte_mask(byte_mask),
      .pre_evt(pre_evt), .stop_evt(stop_evt), .dq_out(dq_out), .dq_oe(dq_oe));

   typedef struct { int when; int src; logic [31:0] d; } exp_t;
   exp_t         q[$];
   logic [3:0]   mask_at [int];
   int           cyc = 0, checks = 0, errors = 0;
   int           mlat = 3;
   bit           mblk = 1'b0;
   string        phase = "R2";

   always @(posedge clk) cyc <= cyc + 1;

   // Driver: sets inputs for the next edge and pushes the expected bus period.
   task automatic tick(bit v, logic [31:0] d, bit f, logic [3:0] m, bit p, bit s, bit ld, logic [2:0] lv);
      int n;
      bit acc;
      @(negedge clk);
      rd_vld = v; rd_data = d; rd_first = f; byte_mask = m;
      pre_evt = p; stop_evt = s; cfg_load = ld; cfg_lat = lv;
      n = cyc + 1;
      mask_at[n] = m;
      if (s) begin
         for (int i = q.size() - 1; i >= 0; i--) if (q[i].src == n - 1) q.delete(i);
      end
      acc = v && !p && !s && (!mblk || f);
      if (p || s) mblk = 1'b1;
      else if (acc && f) mblk = 1'b0;
      if (acc) q.push_back('{n + mlat - 1, n, d});
      if (ld && (lv == 3'b010 || lv == 3'b011)) mlat = int'(lv);
   endtask

   task automatic idle(int k);
      for (int i = 0; i < k; i++) tick(0, '0, 0, '0, 0, 0, 0, '0);
   endtask
   task automatic word(logic [31:0] d, bit f, logic [3:0] m);
      tick(1, d, f, m, 0, 0, 0, '0);
   endtask
   task automatic load(logic [2:0] lv);
      tick(0, '0, 0, '0, 0, 0, 1, lv);
   endtask

   // Monitor: compares the bus in every period against the scoreboard.
   always @(negedge clk) begin
      logic [3:0]  mk, eo;
      logic [31:0] ed;
      mk = mask_at.exists(cyc - 1) ? mask_at[cyc - 1] : 4'h0;
      eo = '0;
      ed = '0;
      while (q.size() > 0 && q[0].when < cyc) begin
         checks++; errors++;
         $display("FAIL %s cycle %0d: word %h never seen, expected at %0d", phase, cyc, q[0].d, q[0].when);
         void'(q.pop_front());
      end
      if (q.size() > 0 && q[0].when == cyc) begin
         eo = rst_n ? ~mk : 4'h0;
         for (int l = 0; l < 4; l++) if (eo[l]) ed[l*8 +: 8] = q[0].d[l*8 +: 8];
         void'(q.pop_front());
      end
      checks++;
      if (dq_oe !== eo || dq_out !== ed) begin
         errors++;
         $display("FAIL %s cycle %0d: oe=%h dq=%h expected oe=%h dq=%h", phase, cyc, dq_oe, dq_out, eo, ed);
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      checks++; errors++;
      $display("FAIL %s watchdog: cycle=%0d expected end before 20000", phase, cyc);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      // R2: reset state, then a single word at the reset latency of three
      idle(3);
      @(negedge clk); rst_n = 1'b1;
      word(32'h1122_3344, 1, '0); idle(5);
      // R3: continuous burst at latency three
      phase = "R3";
      for (int k = 0; k < 5; k++) word(32'hB000_0000 + k, k == 0, '0);
      idle(5);
      // R1: illegal codes keep three, then a legal load of two
      phase = "R1";
      load(3'b001); load(3'b111); load(3'b000); load(3'b100);
      word(32'hC000_0001, 1, '0); idle(5);
      load(3'b010);
      word(32'hC000_0002, 1, '0); idle(4);
      // R3: burst interrupted by a new burst, back to back at latency two
      phase = "R3";
      for (int k = 0; k < 6; k++) word(32'hD000_0000 + k, k == 0 || k == 3, '0);
      idle(4);
      // R4: byte masks at latency two, then at latency three
      phase = "R4";
      for (int k = 0; k < 8; k++) word(32'hE0E1_E2E3 + k, k == 0, 4'(k * 5));
      idle(4);
      load(3'b011);
      for (int k = 0; k < 6; k++) word(32'hF0F1_F2F3 + k, k == 0, 4'(1 << (k % 4)));
      idle(4);
      // R6 and R7: burst stop at latency three, then at latency two
      phase = "R6";
      for (int k = 0; k < 4; k++) word(32'h6000_0000 + k, k == 0, '0);
      tick(1, 32'h6000_0004, 0, '0, 0, 1, 0, '0);
      phase = "R7";
      word(32'h6000_0005, 0, '0); word(32'h6000_0006, 0, '0);
      word(32'h6000_0007, 1, '0); word(32'h6000_0008, 0, '0);
      idle(5);
      load(3'b010); idle(3);
      phase = "R6";
      for (int k = 0; k < 4; k++) word(32'h6100_0000 + k, k == 0, '0);
      tick(1, 32'h6100_0004, 0, '0, 0, 1, 0, '0);
      word(32'h6100_0005, 0, '0); word(32'h6100_0006, 1, '0);
      idle(5);
      // R5: precharge at latency two, then at latency three
      phase = "R5";
      for (int k = 0; k < 4; k++) word(32'h5000_0000 + k, k == 0, '0);
      tick(1, 32'h5000_0004, 0, '0, 1, 0, 0, '0);
      word(32'h5000_0005, 0, '0); idle(5);
      load(3'b011); idle(3);
      for (int k = 0; k < 4; k++) word(32'h5100_0000 + k, k == 0, '0);
      tick(1, 32'h5100_0004, 0, '0, 1, 0, 0, '0);
      word(32'h5100_0005, 0, '0); word(32'h5100_0006, 1, '0);
      idle(5);
      // R8: latency change while a word is queued
      phase = "R8";
      word(32'h8000_0003, 1, '0); load(3'b010); word(32'h8000_0002, 1, '0);
      idle(5);
      word(32'h8100_0002, 1, '0); load(3'b011); word(32'h8100_0003, 1, '0);
      idle(6);
      checks++;
      if (q.size() != 0) begin
         errors++;
         $display("FAIL R3 end: %0d words pending, expected 0", q.size());
      end
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end
endmodule